// File: doc/BRIEF.md
# Drawing command packet framer

This block takes an unframed stream of 32-bit command words and cuts it into whole drawing packets. The top byte of a packet's first word is the opcode. The block decodes from that opcode how many parameter words come after it. It then forwards the first word and each following word unchanged, with a start marker on the first word and an end marker on the last. Polyline opcodes have no fixed length: they run until an in-band terminator word arrives, or until a hard word limit is reached.

Two opcode groups never produce a packet. The memory-transfer group swallows the next two words, a position and a size, and reports them on a side port as a one-cycle pulse. The environment group stores the whole word in one of eight environment registers. Some bits of two of these registers are mirrored onto a status output. A packet may arrive in pieces: gaps in the input stream do not disturb the framing.

Both stream edges use valid/ready. A word is transferred on a cycle where valid and ready are both high. While a packet word is on the output, the input ready follows the output ready combinationally, so a stalled consumer stalls the producer with no buffering in between. Opcode words of the transfer and environment groups, and the position and size words, are always accepted at once.

Top module: `cmd_framer`

## Requirements
- R1: The number of words after the opcode word follows the opcode: 0x02 gives 2; 0x20-0x3F give 3 or 4 vertices (opcode bit 3), each vertex having one word plus one more when bit 2 is set, plus one word for each vertex after the first when bit 4 is set; 0x40-0x5F give 2 plus bit 4 plus bit 3; 0x60-0x7F give 1 plus bit 2 plus one more when bits 4:3 are 00, except 0x6C-0x6F, which give 0; 0x80 gives 3; every other opcode outside the transfer and environment groups gives 0.
- R2: Each packet word appears on the output in input order, with out_data equal to in_data. out_sop is high only on the opcode word and out_eop only on the last word.
- R3: Opcodes 0x48-0x4F are flat polylines. Their packet ends on the first word at index 3 or later (the opcode word is index 0) for which (word & 0xF000F000) == 0x50005000. Opcodes 0x58-0x5F are shaded polylines and test only the even indices from 4 upward. Words that match at any other index are passed through as plain data.
- R4: A polyline that has no terminator is closed with out_eop on its 256th word, and the word after that is decoded as a new opcode.
- R5: Opcodes 0xA0-0xDF produce no output words. The next two input words are taken as position and size, and are never decoded as opcodes. One cycle after the size word is accepted, xfer_valid is high for exactly one cycle with xfer_pos, xfer_size and xfer_read. xfer_read is 1 when opcode bits 7:5 are 110.
- R6: Opcodes 0xE0-0xE7 produce no output words and write the whole word into environment register (opcode - 0xE0), which is visible on env_regs bits [32*i+31:32*i]. After reset, register i holds (0xE0+i)<<24.
- R7: status_bits[10:0] equal bits 10:0 of environment register 1, and status_bits[12:11] equal bits 1:0 of environment register 6.
- R8: While out_valid is high and out_ready is low, in_ready is low, and no word is lost or repeated.
- R9: Cycles with in_valid low inside a packet or a transfer leave the framing unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_data | input | 32 | Input command word |
| out_valid | output | 1 | Packet word valid |
| out_ready | input | 1 | Downstream accepts packet word |
| out_data | output | 32 | Packet word |
| out_sop | output | 1 | First word of packet |
| out_eop | output | 1 | Last word of packet |
| xfer_valid | output | 1 | One-cycle pulse: transfer request ready |
| xfer_read | output | 1 | Transfer direction, 1 = read |
| xfer_pos | output | 32 | Transfer position word |
| xfer_size | output | 32 | Transfer size word |
| status_bits | output | 13 | Mirrored environment bits |
| env_regs | output | 256 | Eight environment registers, register i at bits 32*i+31:32*i |

## Verification
The bench sends every opcode outside the two side groups and compares the packet length with a value it computes from the opcode bits. A wrong table entry, such as the zero-length quirk at 0x6C, would shift every later packet boundary. Polylines are given decoy terminator patterns at indices that must not end them, including odd indices for shaded lines. A design that checks every index or starts too early would cut those lines short. An unterminated line must close at exactly 256 words. The sweep is repeated with a stalling consumer and with gaps in the input, because a ready path that ignored the consumer would drop or repeat words. Transfer position words carry a valid packet opcode in their top byte, so a design that decoded them as opcodes would emit stray packets.

// File: rtl/cmd_framer_pkg.sv
package cmd_framer_pkg;

  localparam int WORD_W = 32;
  localparam logic [WORD_W-1:0] TERM_MASK = 32'hF000_F000;
  localparam logic [WORD_W-1:0] TERM_CODE = 32'h5000_5000;
  localparam int FLAT_FIRST   = 3;
  localparam int SHADED_FIRST = 4;
  localparam logic [7:0] ENV_BASE = 8'hE0;

  typedef enum logic [1:0] {
    ST_HEAD,
    ST_BODY,
    ST_XPOS,
    ST_XSIZE
  } fr_state_e;

  typedef enum logic [1:0] {
    PL_NONE,
    PL_FLAT,
    PL_SHADED
  } poly_e;

  function automatic logic [3:0] param_words(input logic [7:0] op);
    logic [3:0] n;
    case (op) inside
      8'h02:          n = 4'd2;
      [8'h20:8'h23]:  n = 4'd3;
      [8'h24:8'h27]:  n = 4'd6;
      [8'h28:8'h2B]:  n = 4'd4;
      [8'h2C:8'h2F]:  n = 4'd8;
      [8'h30:8'h33]:  n = 4'd5;
      [8'h34:8'h37]:  n = 4'd8;
      [8'h38:8'h3B]:  n = 4'd7;
      [8'h3C:8'h3F]:  n = 4'd11;
      [8'h40:8'h47]:  n = 4'd2;
      [8'h48:8'h57]:  n = 4'd3;
      [8'h58:8'h5F]:  n = 4'd4;
      [8'h60:8'h63]:  n = 4'd2;
      [8'h64:8'h67]:  n = 4'd3;
      [8'h68:8'h6B]:  n = 4'd1;
      [8'h70:8'h73]:  n = 4'd1;
      [8'h74:8'h77]:  n = 4'd2;
      [8'h78:8'h7B]:  n = 4'd1;
      [8'h7C:8'h7F]:  n = 4'd2;
      8'h80:          n = 4'd3;
      8'hA0, 8'hC0:   n = 4'd2;
      default:        n = 4'd0;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/cmd_op_decode.sv
module cmd_op_decode
  import cmd_framer_pkg::*;
#(
  parameter int NENV = 8
) (
  input  logic [7:0] op,
  output logic [3:0] extra,
  output poly_e      kind,
  output logic       is_xfer,
  output logic       xfer_rd,
  output logic       is_env
);

  always_comb begin
    extra = param_words(op);
    if (op[7:3] == 5'b01001)      kind = PL_FLAT;
    else if (op[7:3] == 5'b01011) kind = PL_SHADED;
    else                          kind = PL_NONE;
    is_xfer = (op >= 8'hA0) && (op <= 8'hDF);
    xfer_rd = (op[7:5] == 3'b110);
    is_env  = (int'(op) >= int'(ENV_BASE)) && (int'(op) < int'(ENV_BASE) + NENV);
  end

endmodule

// File: rtl/cmd_env_bank.sv
module cmd_env_bank
  import cmd_framer_pkg::*;
#(
  parameter int NENV = 8,
  localparam int EW = (NENV > 1) ? $clog2(NENV) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [EW-1:0]          sel,
  input  logic [WORD_W-1:0]      wdata,
  output logic [NENV*WORD_W-1:0] regs_flat
);

  for (genvar g = 0; g < NENV; g++) begin : g_reg
    logic [WORD_W-1:0] r_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        r_q <= WORD_W'(int'(ENV_BASE) + g) << 24;
      else if (we && (sel == EW'(g)))
        r_q <= wdata;
    end
    assign regs_flat[g*WORD_W +: WORD_W] = r_q;
  end

endmodule

// File: rtl/cmd_xfer_capture.sv
module cmd_xfer_capture
  import cmd_framer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_we,
  input  logic              start_rd,
  input  logic              pos_we,
  input  logic              size_we,
  input  logic [WORD_W-1:0] word,
  output logic              xfer_valid,
  output logic              xfer_read,
  output logic [WORD_W-1:0] xfer_pos,
  output logic [WORD_W-1:0] xfer_size
);

  logic rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q       <= 1'b0;
      xfer_valid <= 1'b0;
      xfer_read  <= 1'b0;
      xfer_pos   <= '0;
      xfer_size  <= '0;
    end else begin
      xfer_valid <= size_we;
      if (start_we) rd_q <= start_rd;
      if (pos_we)   xfer_pos <= word;
      if (size_we) begin
        xfer_size <= word;
        xfer_read <= rd_q;
      end
    end
  end

endmodule

// File: rtl/cmd_framer.sv
module cmd_framer
  import cmd_framer_pkg::*;
#(
  parameter int NENV     = 8,
  parameter int POLY_MAX = 256
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [31:0]            in_data,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [31:0]            out_data,
  output logic                   out_sop,
  output logic                   out_eop,
  output logic                   xfer_valid,
  output logic                   xfer_read,
  output logic [31:0]            xfer_pos,
  output logic [31:0]            xfer_size,
  output logic [12:0]            status_bits,
  output logic [NENV*32-1:0]     env_regs
);

  localparam int IW = $clog2(POLY_MAX);
  localparam int EW = (NENV > 1) ? $clog2(NENV) : 1;

  fr_state_e     state_q;
  logic [IW-1:0] idx_q;
  logic [IW-1:0] len_q;
  poly_e         kind_q;

  logic [7:0] op;
  logic [3:0] d_extra;
  poly_e      d_kind;
  logic       d_xfer, d_rd, d_env;
  logic       term, at_limit, body_end, acc;

  assign op = in_data[31:24];

  cmd_op_decode #(.NENV(NENV)) u_dec (
    .op      (op),
    .extra   (d_extra),
    .kind    (d_kind),
    .is_xfer (d_xfer),
    .xfer_rd (d_rd),
    .is_env  (d_env)
  );

  assign term     = ((in_data & TERM_MASK) == TERM_CODE);
  assign at_limit = (idx_q == IW'(POLY_MAX - 1));

  always_comb begin
    case (kind_q)
      PL_FLAT:   body_end = (term && (idx_q >= IW'(FLAT_FIRST))) || at_limit;
      PL_SHADED: body_end = (term && (idx_q >= IW'(SHADED_FIRST)) && !idx_q[0]) || at_limit;
      default:   body_end = (idx_q == len_q);
    endcase
  end

  always_comb begin
    out_valid = 1'b0;
    in_ready  = 1'b0;
    out_sop   = 1'b0;
    out_eop   = 1'b0;
    case (state_q)
      ST_HEAD: begin
        if (d_xfer || d_env) begin
          in_ready = 1'b1;
        end else begin
          out_valid = in_valid;
          in_ready  = out_ready;
          out_sop   = 1'b1;
          out_eop   = (d_extra == 4'd0);
        end
      end
      ST_BODY: begin
        out_valid = in_valid;
        in_ready  = out_ready;
        out_eop   = body_end;
      end
      default: in_ready = 1'b1;
    endcase
  end

  assign out_data = in_data;
  assign acc      = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_HEAD;
      idx_q   <= '0;
      len_q   <= '0;
      kind_q  <= PL_NONE;
    end else if (acc) begin
      case (state_q)
        ST_HEAD: begin
          if (d_xfer) begin
            state_q <= ST_XPOS;
          end else if (!d_env && (d_extra != 4'd0)) begin
            state_q <= ST_BODY;
            idx_q   <= IW'(1);
            len_q   <= IW'(d_extra);
            kind_q  <= d_kind;
          end
        end
        ST_BODY: begin
          if (body_end) state_q <= ST_HEAD;
          else          idx_q   <= idx_q + IW'(1);
        end
        ST_XPOS:  state_q <= ST_XSIZE;
        default:  state_q <= ST_HEAD;
      endcase
    end
  end

  cmd_env_bank #(.NENV(NENV)) u_env (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (acc && (state_q == ST_HEAD) && d_env),
    .sel       (EW'(op - ENV_BASE)),
    .wdata     (in_data),
    .regs_flat (env_regs)
  );

  cmd_xfer_capture u_xfer (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_we   (acc && (state_q == ST_HEAD) && d_xfer),
    .start_rd   (d_rd),
    .pos_we     (acc && (state_q == ST_XPOS)),
    .size_we    (acc && (state_q == ST_XSIZE)),
    .word       (in_data),
    .xfer_valid (xfer_valid),
    .xfer_read  (xfer_read),
    .xfer_pos   (xfer_pos),
    .xfer_size  (xfer_size)
  );

  assign status_bits = {env_regs[6*32 +: 2], env_regs[1*32 +: 11]};

endmodule

// File: rtl/cmd_framer_chk.sv
module cmd_framer_chk #(
  parameter int NENV     = 8,
  parameter int POLY_MAX = 256
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic               out_sop,
  input logic               out_eop,
  input logic               xfer_valid,
  input logic [NENV*32-1:0] env_regs
);

  localparam int CW = $clog2(POLY_MAX) + 1;

  logic          open_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
    end else if (out_valid && out_ready) begin
      if (out_eop) begin
        open_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        open_q <= 1'b1;
        cnt_q  <= cnt_q + CW'(1);
      end
    end
  end

  AST_SOP_FIRST: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !open_q) |-> out_sop); // R2
  AST_SOP_ONCE: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && open_q) |-> !out_sop); // R2
  AST_POLY_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) cnt_q < CW'(POLY_MAX)); // R4
  AST_XFER_PULSE: assert property (@(posedge clk) disable iff (!rst_n) xfer_valid |=> !xfer_valid); // R5
  AST_ENV_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !(in_valid && in_ready) |=> $stable(env_regs)); // R6
  AST_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_ready) |-> !in_ready); // R8

endmodule

bind cmd_framer cmd_framer_chk #(.NENV(NENV), .POLY_MAX(POLY_MAX)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_sop    (out_sop),
  .out_eop    (out_eop),
  .xfer_valid (xfer_valid),
  .env_regs   (env_regs)
);

// File: tb/tb_cmd_framer.sv
`timescale 1ns/1ps
module tb_cmd_framer;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [31:0]  in_data = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [31:0]  out_data;
  logic         out_sop, out_eop;
  logic         xfer_valid, xfer_read;
  logic [31:0]  xfer_pos, xfer_size;
  logic [12:0]  status_bits;
  logic [255:0] env_regs;

  cmd_framer dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_sop(out_sop),
    .out_eop(out_eop), .xfer_valid(xfer_valid), .xfer_read(xfer_read), .xfer_pos(xfer_pos),
    .xfer_size(xfer_size), .status_bits(status_bits), .env_regs(env_regs)
  );

  always #2 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit bp_mode = 0;
  bit gap_mode = 0;
  int bp_viol = 0;
  int stalls = 0;
  logic [31:0] got_d [512];
  bit          got_s [512];
  bit          got_e [512];
  int          got_n = 0;
  int          x_n = 0;
  logic [31:0] x_pos, x_size;
  logic        x_rd;
  logic [31:0] exp_d [512];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(output bit hs);
    if (bp_mode) out_ready = (cyc % 3) != 0;
    else         out_ready = 1'b1;
    #1;
    if (out_valid && out_ready) begin
      if (got_n < 512) begin
        got_d[got_n] = out_data;
        got_s[got_n] = out_sop;
        got_e[got_n] = out_eop;
      end
      got_n++;
    end
    if (out_valid && !out_ready) begin
      stalls++;
      if (in_ready) bp_viol++;
    end
    if (xfer_valid) begin
      x_n++;
      x_pos = xfer_pos;
      x_size = xfer_size;
      x_rd = xfer_read;
    end
    hs = in_valid && in_ready;
    @(posedge clk);
    @(negedge clk);
    cyc++;
  endtask

  task automatic idle(input int n);
    bit hs;
    for (int i = 0; i < n; i++) step(hs);
  endtask

  task automatic push(input logic [31:0] w);
    bit hs;
    in_valid = 1'b1;
    in_data = w;
    do step(hs); while (!hs);
    in_valid = 1'b0;
    if (gap_mode) idle(1 + (cyc % 2));
  endtask

  function automatic int exp_len(input logic [7:0] op);
    int v;
    if (op == 8'h02) return 2;
    if (op >= 8'h20 && op <= 8'h3F) begin
      v = op[3] ? 4 : 3;
      return v * (1 + int'(op[2])) + (op[4] ? v - 1 : 0);
    end
    if (op >= 8'h40 && op <= 8'h5F) return 2 + int'(op[4]) + int'(op[3]);
    if (op >= 8'h60 && op <= 8'h7F) begin
      if (op[4:2] == 3'b011) return 0;
      return 1 + int'(op[2]) + ((op[4:3] == 2'b00) ? 1 : 0);
    end
    if (op == 8'h80) return 3;
    return 0;
  endfunction

  // Sends n words; word at index term_at is a terminator, decoys at decoy_a/decoy_b.
  task automatic send_pkt(input string req, input logic [7:0] op, input int n,
                          input int term_at, input int decoy_a, input int decoy_b);
    int bad;
    got_n = 0;
    for (int k = 0; k < n; k++) begin
      if (k == 0)                            exp_d[k] = {op, 24'h000123};
      else if (k == term_at)                 exp_d[k] = 32'h5ABC_5DEF;
      else if (k == decoy_a || k == decoy_b) exp_d[k] = 32'h5123_5456;
      else                                   exp_d[k] = 32'h0001_0000 | k;
      push(exp_d[k]);
    end
    idle(1);
    check(got_n == n, req, $sformatf("word count op=%02h", op), got_n, n);
    bad = 0;
    for (int k = 0; k < n && k < got_n; k++)
      if (got_d[k] !== exp_d[k] || got_s[k] !== (k == 0) || got_e[k] !== (k == n - 1)) bad++;
    check(bad == 0, "R2", $sformatf("data/sop/eop op=%02h", op), bad, 0);
  endtask

  task automatic sweep(input string tag);
    int n;
    bit flat, shaded;
    for (int o = 0; o < 256; o++) begin
      logic [7:0] op;
      op = 8'(o);
      if ((op >= 8'hA0 && op <= 8'hDF) || (op >= 8'hE0 && op <= 8'hE7)) continue;
      n = exp_len(op) + 1;
      flat = (op[7:3] == 5'b01001);
      shaded = (op[7:3] == 5'b01011);
      send_pkt(tag, op, n, (flat || shaded) ? n - 1 : -1, -1, -1);
    end
  endtask

  task automatic xfer_case(input logic [7:0] op, input logic [31:0] pos, input logic [31:0] sz);
    bit rd;
    rd = (op[7:5] == 3'b110);
    got_n = 0;
    x_n = 0;
    push({op, 24'h000000});
    push(pos);
    push(sz);
    idle(2);
    check(x_n == 1, "R5", $sformatf("pulse count op=%02h", op), x_n, 1);
    check(x_pos == pos && x_size == sz, "R5", "pos/size", {x_pos, x_size}, {pos, sz});
    check(x_rd == rd, "R5", $sformatf("read flag op=%02h", op), x_rd, rd);
    check(got_n == 0, "R5", "no output words", got_n, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // reset state: R6, R7
    bad = 0;
    for (int i = 0; i < 8; i++)
      if (env_regs[i*32 +: 32] !== (32'(224 + i) << 24)) bad++;
    check(bad == 0, "R6", "env reset values", bad, 0);
    check(status_bits == 13'h0, "R7", "status after reset", status_bits, 0);
    check(!out_valid && !xfer_valid, "R2", "outputs idle after reset", {out_valid, xfer_valid}, 0);
    @(negedge clk);

    sweep("R1");
    bp_mode = 1;
    sweep("R8");
    check(bp_viol == 0, "R8", "in_ready high during stall", bp_viol, 0);
    check(stalls > 0, "R8", "stalls exercised", stalls, 1);
    bp_mode = 0;
    gap_mode = 1;
    sweep("R9");
    bp_mode = 1;

    // R3 polylines with decoys, under gaps and stalls
    send_pkt("R3", 8'h48, 8, 7, 1, 2);
    send_pkt("R3", 8'h4F, 4, 3, -1, -1);
    send_pkt("R3", 8'h58, 9, 8, 5, 7);
    send_pkt("R3", 8'h5C, 11, 10, 3, 9);
    bp_mode = 0;
    gap_mode = 0;
    send_pkt("R3", 8'h5A, 7, 6, 1, 5);

    // R4 forced close, then next word is an opcode
    send_pkt("R4", 8'h4A, 256, -1, -1, -1);
    send_pkt("R4", 8'h6D, 1, -1, -1, -1);
    send_pkt("R4", 8'h5E, 256, -1, 5, 255);
    send_pkt("R4", 8'h20, 4, -1, -1, -1);

    // R5 transfers; position words carry packet opcodes to catch misframing
    xfer_case(8'hA0, 32'h2800_0010, 32'h0020_0040);
    xfer_case(8'hC0, 32'h3C12_3456, 32'h0001_0001);
    xfer_case(8'hDF, 32'h0000_03FF, 32'h01FF_0400);
    xfer_case(8'hBF, 32'h8000_0001, 32'hE100_0000);
    gap_mode = 1;
    xfer_case(8'hC7, 32'h0246_8ACE, 32'h1357_9BDF);
    gap_mode = 0;
    send_pkt("R5", 8'h28, 5, -1, -1, -1);

    // R6 environment writes
    for (int i = 0; i < 8; i++) begin
      logic [31:0] w;
      w = {8'(224 + i), 24'(32'h0A5A5A ^ (i * 32'h111111))};
      got_n = 0;
      push(w);
      idle(1);
      check(env_regs[i*32 +: 32] == w, "R6", $sformatf("env reg %0d", i), env_regs[i*32 +: 32], w);
      check(got_n == 0, "R6", "env write emits nothing", got_n, 0);
    end

    // R7 status mirror
    push(32'hE1FF_FABC);
    push(32'hE600_0003);
    idle(1);
    check(status_bits == 13'((32'h3 << 11) | (32'hFFFABC & 32'h7FF)), "R7", "status mirror",
          status_bits, 13'((32'h3 << 11) | (32'hFFFABC & 32'h7FF)));
    push(32'hE100_0400);
    push(32'hE6FF_FFFC);
    idle(1);
    check(status_bits == 13'h0400, "R7", "status mirror 2", status_bits, 13'h0400);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule